// File: doc/BRIEF.md
# Serial Flash Controller Status Flag Unit

This block keeps the status flags and the FIFO byte count for a controller that talks to a quad-lane serial flash device. The controller core sends it single-cycle event pulses: operation start and end, timeout, polled value capture, transfer count reached, abort and invalid address. It also sends FIFO push and pop strobes, a programmed FIFO threshold, the operating mode and a data-register read strobe. The unit folds all of these into one 32-bit read-only status word.

Software clears the sticky flags by writing ones to a separate clear word. The FIFO threshold flag and the level field change meaning with the operating mode. Busy stays high until the flash operation has ended and the FIFO has drained. All state is registered, and the status word follows that state one clock after the causing edge. The level field and the threshold flag also depend on the current mode input, with no added delay.

Top module: `qflash_stat_unit`

## Requirements
- R1: After reset the status word is all zeros. Bits 31:14 and bits 7:6 always read zero.
- R2: The byte count goes up by one on a push and down by one on a pop. A push and a pop in the same cycle leave it unchanged. A push at FIFO_DEPTH and a pop at 0 are ignored. Bits 13:8 show the count in indirect mode (mode 2'b00) and read zero in any other mode.
- R3: Bit 5 (busy) is high from the edge after an operation start until an operation end has been seen and the byte count is zero. It is also high whenever the count is nonzero.
- R4: Bit 4 (timeout) sets on a timeout pulse and holds until cleared by a write of clear bit 4.
- R5: Bit 3 (match) sets only on a capture cycle in automatic polling mode (2'b01) where ((data XOR match) AND mask) is zero. It holds until cleared by a write of clear bit 3.
- R6: In indirect mode, bit 2 is high while count >= threshold, or while no operation is active and the count is nonzero. In memory-mapped mode (2'b10) and in mode 2'b11, bit 2 reads zero.
- R7: In automatic polling mode, bit 2 sets on each capture and clears on a data-register read. A capture in the same cycle as a read wins. Writes to clear bit 2 have no effect.
- R8: Bit 1 (transfer complete) sets on a count-reached pulse in indirect mode and on an abort in any mode. It holds until cleared by a write of clear bit 1.
- R9: Bit 0 (transfer error) sets on an invalid-address pulse in indirect mode only. It holds until cleared by a write of clear bit 0.
- R10: A clear write acts only on the flags whose clear bits are 1. When a set event and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 indirect, 01 automatic polling, 10 memory-mapped, 11 reserved |
| op_start_i | input | 1 | Flash operation start pulse |
| op_end_i | input | 1 | Flash operation end pulse |
| timeout_i | input | 1 | Timeout event pulse |
| poll_cap_i | input | 1 | Polled status value captured |
| poll_data_i | input | DATA_W | Captured polled value |
| match_val_i | input | DATA_W | Value to match against |
| match_mask_i | input | DATA_W | Bits taking part in the match |
| xfer_done_i | input | 1 | Programmed byte count reached |
| abort_i | input | 1 | Transfer aborted |
| bad_addr_i | input | 1 | Invalid address accessed |
| fifo_push_i | input | 1 | One byte entered the FIFO |
| fifo_pop_i | input | 1 | One byte left the FIFO |
| fifo_thr_i | input | LVL_W | FIFO threshold in bytes, 1 to FIFO_DEPTH |
| data_rd_i | input | 1 | Data register read strobe |
| clr_we_i | input | 1 | Flag-clear write strobe |
| clr_data_i | input | 5 | Clear bits, same positions as status bits 4:0 |
| status_o | output | 32 | Status word |

## Verification
The bench builds the unit with FIFO_DEPTH=8 and DATA_W=8. LVL_W is then 4 bits, which the unit pads into the 6-bit field. The shallow depth means the full-FIFO saturation, threshold crossings and the drain back to zero each take only a few pushes and pops. The narrow polled value still leaves room for masked and unmasked mismatch bits. Every clock, the bench compares the whole status word with a behavioural model, so each mode switch shows up at once in the level field and the threshold flag.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
   typedef enum logic [1:0] {
      QM_IND  = 2'b00,
      QM_POLL = 2'b01,
      QM_MMAP = 2'b10,
      QM_RSVD = 2'b11
   } qfs_mode_e;

   localparam int unsigned STAT_W     = 32;
   localparam int unsigned FIELD_W    = 6;
   localparam int unsigned FIELD_LSB  = 8;
   localparam int unsigned BUSY_BIT   = 5;
   localparam int unsigned NFLAG      = 5;
   localparam int unsigned FTF_IDX    = 2;
endpackage

// File: rtl/qfs_level_ctr.sv
module qfs_level_ctr #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [LVL_W-1:0] lvl_o
);
   localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

   logic inc, dec;
   assign inc = push_i && !pop_i && (lvl_o != FULL);
   assign dec = pop_i && !push_i && (lvl_o != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lvl_o <= '0;
      else if (inc) lvl_o <= lvl_o + 1'b1;
      else if (dec) lvl_o <= lvl_o - 1'b1;
   end
endmodule

// File: rtl/qfs_flag.sv
module qfs_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/qfs_match.sv
module qfs_match #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] match_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic              hit_o
);
   assign hit_o = ~|((data_i ^ match_i) & mask_i);
endmodule

// File: rtl/qflash_stat_unit.sv
module qflash_stat_unit
   import qfs_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              op_start_i,
   input  logic              op_end_i,
   input  logic              timeout_i,
   input  logic              poll_cap_i,
   input  logic [DATA_W-1:0] poll_data_i,
   input  logic [DATA_W-1:0] match_val_i,
   input  logic [DATA_W-1:0] match_mask_i,
   input  logic              xfer_done_i,
   input  logic              abort_i,
   input  logic              bad_addr_i,
   input  logic              fifo_push_i,
   input  logic              fifo_pop_i,
   input  logic [LVL_W-1:0]  fifo_thr_i,
   input  logic              data_rd_i,
   input  logic              clr_we_i,
   input  logic [4:0]        clr_data_i,
   output logic [31:0]       status_o
);
   generate
      if (FIFO_DEPTH < 1 || FIFO_DEPTH > 63)
         $error("FIFO_DEPTH must lie in 1..63 to fit the level field");
      if (DATA_W < 1)
         $error("DATA_W must be at least 1");
      if (LVL_W > FIELD_W)
         $error("LVL_W exceeds the level field width");
   endgenerate

   qfs_mode_e mode;
   assign mode = qfs_mode_e'(mode_i);

   logic is_ind, is_poll;
   assign is_ind  = (mode == QM_IND);
   assign is_poll = (mode == QM_POLL);

   // byte count
   logic [LVL_W-1:0] lvl;
   qfs_level_ctr #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (fifo_push_i),
      .pop_i  (fifo_pop_i),
      .lvl_o  (lvl)
   );

   // operation-in-flight marker
   logic op_act;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          op_act <= 1'b0;
      else if (op_start_i) op_act <= 1'b1;
      else if (op_end_i)   op_act <= 1'b0;
   end

   // polled value compare
   logic hit;
   qfs_match #(.DATA_W(DATA_W)) u_match (
      .data_i  (poll_data_i),
      .match_i (match_val_i),
      .mask_i  (match_mask_i),
      .hit_o   (hit)
   );

   // sticky flags, indexed by status bit position; slot FTF_IDX holds the
   // polling-mode threshold flag, cleared by data reads rather than writes
   logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
   assign fl_set[0] = bad_addr_i && is_ind;
   assign fl_set[1] = (xfer_done_i && is_ind) || abort_i;
   assign fl_set[2] = poll_cap_i && is_poll;
   assign fl_set[3] = poll_cap_i && is_poll && hit;
   assign fl_set[4] = timeout_i;

   generate
      for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
         if (gi == FTF_IDX) begin : g_rd_clr
            assign fl_clr[gi] = data_rd_i;
         end else begin : g_w1c
            assign fl_clr[gi] = clr_we_i && clr_data_i[gi];
         end
         qfs_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (fl_set[gi]),
            .clr_i (fl_clr[gi]),
            .q_o   (fl_q[gi])
         );
      end
   endgenerate

   // threshold flag by mode
   logic ftf;
   always_comb begin
      unique case (mode)
         QM_IND:  ftf = (lvl >= fifo_thr_i) || (!op_act && (lvl != '0));
         QM_POLL: ftf = fl_q[FTF_IDX];
         default: ftf = 1'b0;
      endcase
   end

   // level field, padded to the fixed field width
   logic [FIELD_W-1:0] lvl_field;
   generate
      if (LVL_W == FIELD_W) begin : g_lvl_full
         assign lvl_field = is_ind ? lvl : '0;
      end else begin : g_lvl_pad
         assign lvl_field = is_ind ? {{(FIELD_W-LVL_W){1'b0}}, lvl} : '0;
      end
   endgenerate

   logic busy;
   assign busy = op_act || (lvl != '0);

   always_comb begin
      status_o = '0;
      status_o[FIELD_LSB +: FIELD_W] = lvl_field;
      status_o[BUSY_BIT]             = busy;
      status_o[4:3]                  = fl_q[4:3];
      status_o[FTF_IDX]              = ftf;
      status_o[1:0]                  = fl_q[1:0];
   end
endmodule

// File: rtl/qfs_stat_chk.sv
module qfs_stat_chk #(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned DATA_W     = 32
) (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  mode_i,
   input logic        op_start_i,
   input logic        timeout_i,
   input logic        abort_i,
   input logic        bad_addr_i,
   input logic        clr_we_i,
   input logic [4:0]  clr_data_i,
   input logic [31:0] status_o
);
   localparam logic [5:0] DEPTH6 = 6'(FIFO_DEPTH);

   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[31:14] == '0) && (status_o[7:6] == 2'b00));

   p_lvl_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[13:8] <= DEPTH6);

   p_lvl_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b00) |-> (status_o[13:8] == '0));

   p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_start_i |=> status_o[5]);

   p_tof_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_i |=> status_o[4]);

   p_tof_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[4] && !(clr_we_i && clr_data_i[4])) |=> status_o[4]);

   p_ftf_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode_i[1] |-> !status_o[2]);

   p_tcf_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> status_o[1]);

   p_tef_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[0] && !(bad_addr_i && mode_i == 2'b00)) |=> !status_o[0]);
endmodule

bind qflash_stat_unit qfs_stat_chk #(
   .FIFO_DEPTH (FIFO_DEPTH),
   .DATA_W     (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_i     (mode_i),
   .op_start_i (op_start_i),
   .timeout_i  (timeout_i),
   .abort_i    (abort_i),
   .bad_addr_i (bad_addr_i),
   .clr_we_i   (clr_we_i),
   .clr_data_i (clr_data_i),
   .status_o   (status_o)
);

// File: tb/qflash_stat_unit_tb.sv
module qflash_stat_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int DW         = 8;
   localparam int LW         = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = 2'b00;
   logic          op_start_i = 0, op_end_i = 0, timeout_i = 0, poll_cap_i = 0;
   logic [DW-1:0] poll_data_i = '0, match_val_i = '0, match_mask_i = '0;
   logic          xfer_done_i = 0, abort_i = 0, bad_addr_i = 0;
   logic          fifo_push_i = 0, fifo_pop_i = 0;
   logic [LW-1:0] fifo_thr_i = LW'(4);
   logic          data_rd_i = 0, clr_we_i = 0;
   logic [4:0]    clr_data_i = '0;
   logic [31:0]   status_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   qflash_stat_unit #(.FIFO_DEPTH(DEPTH), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .op_start_i(op_start_i),
      .op_end_i(op_end_i), .timeout_i(timeout_i), .poll_cap_i(poll_cap_i),
      .poll_data_i(poll_data_i), .match_val_i(match_val_i),
      .match_mask_i(match_mask_i), .xfer_done_i(xfer_done_i),
      .abort_i(abort_i), .bad_addr_i(bad_addr_i), .fifo_push_i(fifo_push_i),
      .fifo_pop_i(fifo_pop_i), .fifo_thr_i(fifo_thr_i), .data_rd_i(data_rd_i),
      .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .status_o(status_o)
   );

   int checks = 0;
   int errors = 0;

   // behavioural model state
   int m_lvl = 0;
   bit m_op = 0, m_tof = 0, m_smf = 0, m_tcf = 0, m_tef = 0, m_pftf = 0;

   function automatic logic [31:0] model_word();
      logic [31:0] w = '0;
      if (mode_i == 2'b00) w[13:8] = 6'(m_lvl);
      w[5] = m_op || (m_lvl != 0);
      w[4] = m_tof;
      w[3] = m_smf;
      if (mode_i == 2'b00)
         w[2] = (m_lvl >= int'(fifo_thr_i)) || (!m_op && m_lvl != 0);
      else if (mode_i == 2'b01)
         w[2] = m_pftf;
      w[1] = m_tcf;
      w[0] = m_tef;
      return w;
   endfunction

   task automatic check(string tag);
      logic [31:0] exp = model_word();
      checks++;
      if (status_o !== exp) begin
         errors++;
         $display("FAIL %s: status actual %h expected %h", tag, status_o, exp);
      end
   endtask

   task automatic idle();
      op_start_i = 0; op_end_i = 0; timeout_i = 0; poll_cap_i = 0;
      xfer_done_i = 0; abort_i = 0; bad_addr_i = 0;
      fifo_push_i = 0; fifo_pop_i = 0; data_rd_i = 0;
      clr_we_i = 0; clr_data_i = '0;
   endtask

   // one clock: model next state from current inputs, then compare
   task automatic cyc(string tag);
      int  n_lvl = m_lvl;
      bit  clr_hit;
      bit  ind  = (mode_i == 2'b00);
      bit  poll = (mode_i == 2'b01);
      if (fifo_push_i && !fifo_pop_i && m_lvl < DEPTH) n_lvl = m_lvl + 1;
      if (fifo_pop_i && !fifo_push_i && m_lvl > 0)     n_lvl = m_lvl - 1;
      @(posedge clk);
      m_lvl = n_lvl;
      if (op_start_i) m_op = 1; else if (op_end_i) m_op = 0;
      clr_hit = clr_we_i && clr_data_i[4];
      if (timeout_i) m_tof = 1; else if (clr_hit) m_tof = 0;
      clr_hit = clr_we_i && clr_data_i[3];
      if (poll && poll_cap_i && (((poll_data_i ^ match_val_i) & match_mask_i) == '0))
         m_smf = 1;
      else if (clr_hit) m_smf = 0;
      clr_hit = clr_we_i && clr_data_i[1];
      if ((ind && xfer_done_i) || abort_i) m_tcf = 1; else if (clr_hit) m_tcf = 0;
      clr_hit = clr_we_i && clr_data_i[0];
      if (ind && bad_addr_i) m_tef = 1; else if (clr_hit) m_tef = 0;
      if (poll && poll_cap_i) m_pftf = 1; else if (data_rd_i) m_pftf = 0;
      @(negedge clk);
      idle();
      check(tag);
   endtask

   initial begin
      idle();
      #(CLK_PERIOD*2 + 1);
      check("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
      cyc("R1 idle");

      // R2 / R6: fill in indirect mode, threshold 4
      for (int i = 0; i < DEPTH; i++) begin
         fifo_push_i = 1; cyc("R2 R6 fill");
      end
      fifo_push_i = 1; cyc("R2 push at full ignored");
      fifo_push_i = 1; fifo_pop_i = 1; cyc("R2 push+pop hold");
      for (int i = 0; i < 5; i++) begin
         fifo_pop_i = 1; cyc("R6 drop below threshold");
      end
      // R3: operation in flight keeps busy, threshold flag follows count only
      op_start_i = 1; cyc("R3 start");
      fifo_pop_i = 1; cyc("R6 below thr while active");
      fifo_pop_i = 1; cyc("R3 busy while active, count 1");
      fifo_pop_i = 1; cyc("R3 busy on op with empty fifo");
      fifo_pop_i = 1; cyc("R2 pop at zero ignored");
      fifo_push_i = 1; cyc("R6 active, below thr");
      fifo_push_i = 1; cyc("R6 active, below thr 2");
      op_end_i = 1; cyc("R6 data left after end");
      fifo_pop_i = 1; cyc("R3 drain");
      fifo_pop_i = 1; cyc("R3 busy clears on empty");
      fifo_push_i = 1; cyc("R2 prep");
      fifo_push_i = 1; cyc("R2 prep 2");
      mode_i = 2'b10; cyc("R2 R6 memmap hides level and flag");
      mode_i = 2'b11; cyc("R2 R6 reserved mode");

      // R5 / R7: automatic polling
      mode_i = 2'b01; cyc("R2 polling hides level");
      match_val_i = 8'hA5; match_mask_i = 8'hF0;
      poll_data_i = 8'hA3; poll_cap_i = 1; cyc("R5 masked match");
      clr_we_i = 1; clr_data_i = 5'b01000; cyc("R5 clear match");
      poll_data_i = 8'hB5; poll_cap_i = 1; cyc("R5 unmasked mismatch");
      data_rd_i = 1; cyc("R7 read clears");
      poll_cap_i = 1; data_rd_i = 1; cyc("R7 capture beats read");
      clr_we_i = 1; clr_data_i = 5'b00100; cyc("R7 clear bit 2 no effect");
      mode_i = 2'b00; poll_data_i = 8'hA5; poll_cap_i = 1; cyc("R5 capture outside polling");
      mode_i = 2'b01; data_rd_i = 1; cyc("R7 read clear");

      // R4 / R10
      timeout_i = 1; cyc("R4 timeout sets");
      clr_we_i = 1; clr_data_i = 5'b01011; cyc("R10 other bits leave timeout");
      clr_we_i = 1; clr_data_i = 5'b10000; timeout_i = 1; cyc("R10 set beats clear");
      clr_we_i = 1; clr_data_i = 5'b10000; cyc("R4 clear timeout");

      // R8 / R9
      xfer_done_i = 1; cyc("R8 count reached outside indirect ignored");
      mode_i = 2'b10; abort_i = 1; cyc("R8 abort in memmap");
      clr_we_i = 1; clr_data_i = 5'b00010; cyc("R8 clear");
      mode_i = 2'b00; xfer_done_i = 1; cyc("R8 count reached indirect");
      bad_addr_i = 1; mode_i = 2'b01; cyc("R9 outside indirect ignored");
      mode_i = 2'b00; bad_addr_i = 1; cyc("R9 indirect sets");
      clr_we_i = 1; clr_data_i = 5'b00000; cyc("R10 zero write no effect");
      clr_we_i = 0; clr_data_i = 5'b11111; cyc("R10 no strobe no effect");
      clr_we_i = 1; clr_data_i = 5'b11111; cyc("R10 clear all");
      cyc("R1 settle");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule